// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A frame opens with a start bit, carries five, seven or eight data bits in a chosen order, optionally adds a parity bit, and closes with one or two stop bits. Bit timing comes from a baud tick input, and each bit lasts a fixed number of ticks. No clock travels with the data.

A write port loads a one-word holding buffer that sits in front of the frame shifter. When the shifter is free, it takes the buffered word, and a buffer-empty pulse lets the producer supply the next word while the current frame is still on the line. A separate transfer-end pulse marks the end of each frame's final stop bit. A word that is waiting starts on the line in the same cycle. The line level can be inverted as a whole, including the idle level.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame goes out as one start bit (logic 0), the data bits, the parity bit when enabled, then the stop bits (logic 1). The line rests at logic 1 when idle and after reset.
- R2: `cfg_len` selects the data length: 2'b00 gives 5 bits, 2'b10 gives 7 bits, 2'b11 gives 8 bits, and the unsupported code 2'b01 gives 8 bits. The data comes from the low bits of the written word.
- R3: With `cfg_msb_first` = 1 the highest selected data bit goes first. With 0 the lowest bit goes first.
- R4: With `cfg_invert` = 1 every level on `txd` is inverted: start, data, parity, stop and idle.
- R5: `cfg_parity` selects the parity bit: 2'b00 means no parity bit, 2'b01 means even (data ones plus parity is even), 2'b10 means odd, and 2'b11 means a bit fixed at 0.
- R6: With `cfg_stop2` = 0 the frame has one stop bit. With 1 it has two.
- R7: Each bit lasts `TICKS_PER_BIT` cycles in which `tick` is high. While `tick` is low, `txd` holds its level.
- R8: `buf_empty_pulse` is high for one cycle as the buffered word moves into the shifter. In that same cycle the start bit appears and `buf_full` is low.
- R9: `tx_end_pulse` is high for one cycle when the final stop bit has ended. If a word is waiting, its start bit begins in that same cycle.
- R10: A write while `buf_full` is high is ignored and leaves the buffered word unchanged. It sets `wr_ovf`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud tick, one cycle per tick |
| cfg_len | input | 2 | Data length code |
| cfg_msb_first | input | 1 | 1 = highest data bit first |
| cfg_invert | input | 1 | 1 = invert the line level |
| cfg_parity | input | 2 | Parity mode |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Word to send |
| buf_full | output | 1 | Holding buffer holds a word |
| wr_ovf | output | 1 | Sticky flag for a write while full |
| buf_empty_pulse | output | 1 | Buffered word taken by the shifter |
| tx_end_pulse | output | 1 | Final stop bit finished |
| txd | output | 1 | Serial line |

## Verification
The bench builds the block with `TICKS_PER_BIT` = 4 instead of the default 16. This keeps each frame within a few dozen cycles, so every combination of length code, bit order, parity mode, stop count and inversion fits into one short run. The short bit period also makes the buffer cases practical: back-to-back frames, a write that hits a full buffer mid-frame, and a frame paused by a tick gap can all be placed at exact bit positions. A pause of several cycles is then long compared with a bit, so a line that fails to hold during the gap shows up clearly.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_msb_first,
  input  logic       cfg_invert,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_stop2,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       buf_full,
  output logic       wr_ovf,
  output logic       buf_empty_pulse,
  output logic       tx_end_pulse,
  output logic       txd
);
  localparam int CNT_W   = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FRAME_W = 12;

  logic [7:0]         hold_q;
  logic               hold_v;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bits_left;
  logic [CNT_W-1:0]   sub_q;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         nbits;

  wire busy       = bits_left != 4'd0;
  wire bit_done   = busy && tick && (sub_q == CNT_W'(TICKS_PER_BIT - 1));
  wire frame_last = bit_done && (bits_left == 4'd1);
  wire load       = hold_v && (!busy || frame_last);

  always_comb begin
    int nd;
    logic [7:0] mask;
    logic       par;
    nd    = (cfg_len == 2'b00) ? 5 : (cfg_len == 2'b10) ? 7 : 8;
    mask  = 8'hFF >> (8 - nd);
    par   = ^(hold_q & mask);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nd)
        frame[1 + i] = cfg_msb_first ? hold_q[3'(nd - 1 - i)] : hold_q[i];
    case (cfg_parity)
      2'b01:   frame[1 + nd] = par;
      2'b10:   frame[1 + nd] = ~par;
      2'b11:   frame[1 + nd] = 1'b0;
      default: ;
    endcase
    nbits = 4'(1 + nd + ((cfg_parity != 2'b00) ? 1 : 0) + (cfg_stop2 ? 2 : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg           <= '1;
      bits_left       <= '0;
      sub_q           <= '0;
      hold_q          <= '0;
      hold_v          <= 1'b0;
      wr_ovf          <= 1'b0;
      buf_empty_pulse <= 1'b0;
      tx_end_pulse    <= 1'b0;
    end else begin
      buf_empty_pulse <= load;
      tx_end_pulse    <= frame_last;
      if (load) begin
        shreg     <= frame;
        bits_left <= nbits;
        sub_q     <= '0;
      end else if (bit_done) begin
        shreg     <= {1'b1, shreg[FRAME_W-1:1]};
        bits_left <= bits_left - 4'd1;
        sub_q     <= '0;
      end else if (busy && tick) begin
        sub_q <= sub_q + CNT_W'(1);
      end
      if (wr_en && hold_v) begin
        wr_ovf <= 1'b1;
        if (load) hold_v <= 1'b0;
      end else if (wr_en) begin
        hold_q <= wr_data;
        hold_v <= 1'b1;
      end else if (load) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign buf_full = hold_v;
  assign txd      = shreg[0] ^ cfg_invert;
endmodule

module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic buf_full,
  input logic wr_ovf,
  input logic buf_empty_pulse,
  input logic tx_end_pulse,
  input logic txd,
  input logic cfg_invert
);
  AST_OVF_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && buf_full) |=> wr_ovf); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |=> wr_ovf); // R10
  AST_TAKE_FREES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty_pulse |-> !buf_full); // R8
  AST_TAKE_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty_pulse |-> (txd == cfg_invert)); // R8
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_pulse |=> !tx_end_pulse); // R9
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end_pulse && !buf_empty_pulse) |-> (txd == !cfg_invert)); // R4
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (.*);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 4;
  localparam int NVEC = 8;
  // {data, len, msb_first, invert, parity, stop2}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hA5, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0},
    {8'hA5, 2'b11, 1'b1, 1'b0, 2'b01, 1'b0},
    {8'h13, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0},
    {8'h5B, 2'b10, 1'b1, 1'b0, 2'b11, 1'b1},
    {8'hC6, 2'b01, 1'b0, 1'b0, 2'b01, 1'b1},
    {8'h3C, 2'b11, 1'b0, 1'b1, 2'b10, 1'b0},
    {8'h7F, 2'b10, 1'b0, 1'b0, 2'b01, 1'b0},
    {8'h1F, 2'b00, 1'b1, 1'b1, 2'b00, 1'b1}
  };

  logic clk = 0, rst_n = 0, tick = 1;
  logic [1:0] cfg_len = 2'b11, cfg_parity = 2'b00;
  logic cfg_msb_first = 0, cfg_invert = 0, cfg_stop2 = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic buf_full, wr_ovf, buf_empty_pulse, tx_end_pulse, txd;

  int checks = 0, errors = 0;
  logic [11:0] got;
  int endn;
  bit be_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx #(.TICKS_PER_BIT(TPB)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void expect_frame(input logic [14:0] v, output logic [11:0] f, output int nb);
    logic [7:0] d = v[14:7];
    int nd = (v[6:5] == 2'b00) ? 5 : (v[6:5] == 2'b10) ? 7 : 8;
    int ones = 0;
    f = '1;
    nb = 0;
    f[nb] = 1'b0; nb++;
    for (int k = 0; k < nd; k++) begin
      logic b = v[4] ? d[nd - 1 - k] : d[k];
      f[nb] = b; nb++;
      ones += b;
    end
    if (v[2:1] != 2'b00) begin
      f[nb] = (v[2:1] == 2'b01) ? logic'(ones % 2) : (v[2:1] == 2'b10) ? logic'(1 - ones % 2) : 1'b0;
      nb++;
    end
    nb += v[0] ? 2 : 1;
  endfunction

  task automatic set_cfg(input logic [14:0] v);
    cfg_len = v[6:5]; cfg_msb_first = v[4]; cfg_invert = v[3];
    cfg_parity = v[2:1]; cfg_stop2 = v[0];
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // Sits at the negedge where the frame's start bit is first visible.
  task automatic wait_start();
    be_seen = 0;
    for (int w = 0; w < 40; w++) begin
      if (txd == cfg_invert) begin be_seen = buf_empty_pulse; return; end
      @(negedge clk);
    end
  endtask

  // n = 0 at the start-bit cycle; optional mid-frame writes and a tick gap.
  task automatic watch(input bit w2, input logic [7:0] d2, input bit w3, input logic [7:0] d3, input int gap);
    int n = 0;
    got = '1;
    endn = -1;
    while (endn < 0 && n < 100) begin
      @(negedge clk);
      n++;
      if (n % TPB == TPB/2 && n / TPB < 12) got[n / TPB] = txd ^ cfg_invert;
      if (tx_end_pulse) endn = n;
      if (w2 && n == 5) begin wr_en = 1; wr_data = d2; end
      if (w2 && n == 6) wr_en = 0;
      if (w3 && n == 9) begin wr_en = 1; wr_data = d3; end
      if (w3 && n == 10) begin
        wr_en = 0;
        @(negedge clk);
        chk(wr_ovf == 1, "R10 overflow flag after write to full buffer", 32'(wr_ovf), 1);
      end
      if (gap > 0 && n == 6) begin
        logic lvl = txd;
        bit stable = 1;
        tick = 0;
        repeat (gap) begin @(negedge clk); if (txd != lvl) stable = 0; end
        tick = 1;
        chk(stable, "R7 line holds while tick low", 32'(stable), 1);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] ef;
    int nb;
    repeat (3) @(negedge clk);
    chk(txd == 1 && !buf_full && !wr_ovf && !buf_empty_pulse && !tx_end_pulse,
        "R1 reset state idle", {27'd0, txd, buf_full, wr_ovf, buf_empty_pulse, tx_end_pulse}, 32'h10);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VEC[i]);
      @(negedge clk);
      chk(txd == !VEC[i][3], "R4 idle level", 32'(txd), 32'(!VEC[i][3]));
      write_word(VEC[i][14:7]);
      wait_start();
      chk(be_seen, "R8 buffer-empty with start bit", 32'(be_seen), 1);
      watch(0, 8'h0, 0, 8'h0, 0);
      expect_frame(VEC[i], ef, nb);
      chk(got == ef, $sformatf("R1 R2 R3 R4 R5 R6 frame vector %0d", i), 32'(got), 32'(ef));
      chk(endn == nb * TPB, $sformatf("R7 R9 frame end cycle vector %0d", i), 32'(endn), 32'(nb * TPB));
      repeat (3) @(negedge clk);
    end

    // Back-to-back with overflow: second word queued mid-frame, third rejected.
    set_cfg(VEC[0]);
    @(negedge clk);
    write_word(8'h3A);
    wait_start();
    watch(1, 8'hC5, 1, 8'h99, 0);
    chk(txd == 0 && buf_empty_pulse, "R9 next start in tx-end cycle", {30'd0, txd, buf_empty_pulse}, 32'h1);
    watch(0, 8'h0, 0, 8'h0, 0);
    expect_frame({8'hC5, VEC[0][6:0]}, ef, nb);
    chk(got == ef, "R10 buffered word kept after rejected write", 32'(got), 32'(ef));
    chk(wr_ovf == 1, "R10 overflow stays set", 32'(wr_ovf), 1);

    // Tick gap mid-frame.
    repeat (2) @(negedge clk);
    set_cfg(VEC[2]);
    write_word(VEC[2][14:7]);
    wait_start();
    watch(0, 8'h0, 0, 8'h0, 7);
    expect_frame(VEC[2], ef, nb);
    chk(got == ef, "R7 frame intact across tick gap", 32'(got), 32'(ef));
    chk(endn == nb * TPB, "R7 bit time counts ticks only", 32'(endn), 32'(nb * TPB));
    chk(!buf_full, "R8 buffer empty after frame", 32'(buf_full), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule